// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in a single combinational pass. The carries come from two levels of lookahead rather than from a ripple chain. The operand is split into four 4-bit slices. Each slice forms per-bit generate (AND of the operand bits) and propagate (OR of the operand bits) terms. From these it expands every internal carry as a sum of products, produces its sum bits as the XOR of the two operand bits and the incoming carry, and passes a slice-level generate and propagate pair upward.

A second-level unit takes the four slice pairs and the carry-in and expands, again as sums of products, the carry entering each slice and the final carry-out. The carry-out is reported for unsigned use. A separate flag marks two's-complement overflow: both operands share a sign and the sum's sign differs from it. There is no clock and no state, so every output follows the present inputs.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `opa + opb + cin`, taken as unsigned numbers.
- R2: `cout` equals bit 16 of the 17-bit unsigned total `opa + opb + cin`.
- R3: A carry-in ripples through a fully propagating operand pair. For example, 0xFFFF + 0x0000 with cin = 1 gives sum 0x0000 and cout 1, and 0xFFFF + 0x0001 with cin = 0 gives the same result.
- R4: A carry made in the lowest slice reaches the carry-out through three slices that only propagate. For example, 0xFFF8 + 0x0008 with cin = 0 gives sum 0x0000 and cout 1. A carry made in one slice and stopped by the next slice does not reach the carry-out: 0x00F0 + 0x0010 gives 0x0100 and cout 0.
- R5: `ovf` is 1 exactly when bit 15 of `opa` equals bit 15 of `opb` and bit 15 of `sum` differs from them. This includes the case where only the carry-in pushes the result out of range: 0x7FFF + 0x0000 with cin = 1 gives ovf 1.
- R6: When bit 15 of `opa` and bit 15 of `opb` differ, `ovf` is 0 whatever `cin` is. `cout` may still be 1 in that case.
- R7: The outputs depend only on the current inputs. After the inputs change, the new results are present within the same clock phase, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| ovf | output | 1 | Two's-complement overflow flag |

## Verification
Uniform random operands seldom produce long carry chains that cross slice boundaries. The two cases that matter most are:
- a carry made low in the word that must pass through several slices which only propagate;
- a carry that one slice creates and the next slice stops.

Directed vectors target both cases: all-ones against a single one, a generate in the lowest slice followed by propagate-only slices, and a slice boundary that stops the carry. The random stream also biases about one vector in four toward complementary operands, so that most bit positions only propagate and the carry-in decides the result. Sign-boundary pairs around 0x7FFF and 0x8000 exercise the overflow flag, including overflow caused by the carry-in alone.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Shared declarations for the lookahead adder: the slice-level
// generate/propagate pair and one sum-of-products carry function used
// by both lookahead levels.
// Assumes: no slice or group is wider than LA_MAX terms.
package cla_pkg;

    localparam int LA_MAX = 16;

    typedef struct packed {
        logic gen;   // the slice creates a carry by itself
        logic prop;  // the slice passes an incoming carry through
    } blk_pg_t;

    // Carry out of position `upto`, written as an OR of product terms:
    // g[j] AND every p above j, plus cin AND p[0..upto].
    function automatic logic la_carry(
        input logic [LA_MAX-1:0] g,
        input logic [LA_MAX-1:0] p,
        input logic              cin,
        input int                upto
    );
        logic acc;
        logic term;
        logic chain;
        chain = cin;
        for (int k = 0; k <= upto; k++) chain = chain & p[k];
        acc = chain;
        for (int j = 0; j <= upto; j++) begin
            term = g[j];
            for (int k = j + 1; k <= upto; k++) term = term & p[k];
            acc = acc | term;
        end
        return acc;
    endfunction

    // Generate term of a whole group: la_carry with no carry-in.
    function automatic logic la_group_gen(
        input logic [LA_MAX-1:0] g,
        input logic [LA_MAX-1:0] p,
        input int                upto
    );
        return la_carry(g, p, 1'b0, upto);
    endfunction

endpackage

// File: rtl/cla_block.sv
// Module cla_block
// One lookahead slice of BW bits. It forms the per-bit generate and
// propagate terms, expands every internal carry from them, produces the
// sum bits, and passes the slice generate/propagate pair upward.
// Assumes: 1 <= BW <= cla_pkg::LA_MAX. The carry-in comes from the
// upper lookahead level. The slice never sees its own carry-out.
module cla_block
    import cla_pkg::*;
#(
    parameter int BW = 4
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          cin,
    output logic [BW-1:0] s,
    output blk_pg_t       pg
);

    localparam int PADW = LA_MAX - BW;

    logic [BW-1:0]     g_bit;
    logic [BW-1:0]     p_bit;
    logic [BW:0]       c_int;
    logic [LA_MAX-1:0] g_ext;
    logic [LA_MAX-1:0] p_ext;

    // Per-bit terms: these depend on the operand bits only.
    always_comb begin
        g_bit = a & b;
        p_bit = a | b;
        g_ext = {{PADW{1'b0}}, g_bit};
        p_ext = {{PADW{1'b0}}, p_bit};
    end

    // Expand every internal carry straight from the terms and cin.
    always_comb begin
        c_int    = '0;
        c_int[0] = cin;
        for (int i = 0; i < BW; i++) c_int[i+1] = la_carry(g_ext, p_ext, cin, i);
    end

    // Sum bits and the slice pair exported to the second level.
    always_comb begin
        s       = a ^ b ^ c_int[BW-1:0];
        pg.prop = &p_bit;
        pg.gen  = la_group_gen(g_ext, p_ext, BW - 1);
    end

    // Checks on this slice: the lookahead output against an arithmetic add.
    logic [BW:0] slice_ref;
    always_comb begin
        slice_ref = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, cin};
        p_slice_sum_r1: assert (s == slice_ref[BW-1:0])
            else $error("R1 slice sum mismatch");
        // R2: the exported pair must reproduce the slice carry-out.
        p_slice_carry_r2: assert ((pg.gen | (pg.prop & cin)) == slice_ref[BW])
            else $error("R2 slice carry mismatch");
        // R4: a slice that generates cannot also be needed to propagate a zero carry-in.
        p_slice_gen_r4: assert (!pg.gen || slice_ref[BW])
            else $error("R4 slice generate without carry");
    end

endmodule

// File: rtl/cla_group_unit.sv
// Module cla_group_unit
// Second lookahead level. From each slice's generate/propagate pair and
// the carry-in, it expands the carry into every slice and the final
// carry-out as sums of products. No carry passes from slice to slice.
// Assumes: 1 <= NB <= cla_pkg::LA_MAX.
module cla_group_unit
    import cla_pkg::*;
#(
    parameter int NB = 4
) (
    input  blk_pg_t       pg [NB],
    input  logic          cin,
    output logic [NB:0]   bc
);

    localparam int PADN = LA_MAX - NB;

    logic [NB-1:0]     bg;
    logic [NB-1:0]     bp;
    logic [LA_MAX-1:0] bg_ext;
    logic [LA_MAX-1:0] bp_ext;

    // Gather the slice pairs into vectors.
    always_comb begin
        for (int k = 0; k < NB; k++) begin
            bg[k] = pg[k].gen;
            bp[k] = pg[k].prop;
        end
        bg_ext = {{PADN{1'b0}}, bg};
        bp_ext = {{PADN{1'b0}}, bp};
    end

    // bc[k] is the carry into slice k. bc[NB] is the carry-out.
    always_comb begin
        bc    = '0;
        bc[0] = cin;
        for (int k = 0; k < NB; k++) bc[k+1] = la_carry(bg_ext, bp_ext, cin, k);
    end

    // R4: a slice carry is present only if some lower slice generates, or cin passes through all of them.
    always_comb begin
        p_group_source_r4: assert (!bc[NB] || (|bg) || (cin && (&bp)))
            else $error("R4 carry-out with no source");
    end

endmodule

// File: rtl/cla16_adder.sv
// Module cla16_adder
// Two-level lookahead adder: WIDTH/BLOCK slices of BLOCK bits under a
// single second-level unit. It also reports the carry-out and the
// two's-complement overflow flag.
// Assumes: WIDTH is a multiple of BLOCK. Purely combinational, so there
// is no clock or reset.
module cla16_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int BLOCK = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int NBLK = WIDTH / BLOCK;
    localparam int MSB  = WIDTH - 1;

    blk_pg_t         slice_pg [NBLK];
    logic [NBLK:0]   slice_cin;

    generate
        for (genvar k = 0; k < NBLK; k++) begin : g_slice
            cla_block #(.BW(BLOCK)) u_slice (
                .a   (opa[k*BLOCK +: BLOCK]),
                .b   (opb[k*BLOCK +: BLOCK]),
                .cin (slice_cin[k]),
                .s   (sum[k*BLOCK +: BLOCK]),
                .pg  (slice_pg[k])
            );
        end
    endgenerate

    cla_group_unit #(.NB(NBLK)) u_group (
        .pg  (slice_pg),
        .cin (cin),
        .bc  (slice_cin)
    );

    // Carry-out and overflow, the latter from the sign bits.
    always_comb begin
        cout = slice_cin[NBLK];
        ovf  = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
    end

    // Whole-word checks against arithmetic done at full width.
    logic [WIDTH:0]        total_ref;
    logic signed [WIDTH:0] signed_ref;
    always_comb begin
        total_ref  = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
        signed_ref = $signed({opa[MSB], opa}) + $signed({opb[MSB], opb})
                   + $signed({{WIDTH{1'b0}}, cin});
        p_word_sum_r1: assert (sum == total_ref[WIDTH-1:0])
            else $error("R1 sum mismatch");
        p_carry_out_r2: assert (cout == total_ref[WIDTH])
            else $error("R2 carry-out mismatch");
        p_no_overflow_r5: assert (ovf == (signed_ref[WIDTH] != signed_ref[MSB]))
            else $error("R5 overflow mismatch");
        p_mixed_sign_r6: assert (!(opa[MSB] != opb[MSB]) || !ovf)
            else $error("R6 overflow on mixed signs");
    end

endmodule

// File: tb/cla16_adder_bench.sv
`timescale 1ns/100ps
module cla16_adder_bench;

    logic        clk;
    logic [15:0] opa;
    logic [15:0] opb;
    logic        cin;
    logic [15:0] sum;
    logic        cout;
    logic        ovf;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    initial clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    cla16_adder u_cla16_adder (
        .opa (opa), .opb (opb), .cin (cin),
        .sum (sum), .cout (cout), .ovf (ovf)
    );

    // Expected 17-bit unsigned total.
    function automatic logic [16:0] exp_total(input logic [15:0] a, b, input logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    // Expected overflow: the true signed result lies outside 16 bits.
    function automatic logic exp_ovf(input logic [15:0] a, b, input logic c);
        int v;
        v = int'($signed(a)) + int'($signed(b)) + int'(c);
        return (v > 32767) || (v < -32768);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive away from the rising edge, settle 1 ns, then compare.
    task automatic apply(input logic [15:0] a, b, input logic c);
        logic [16:0] t;
        @(negedge clk);
        opa = a; opb = b; cin = c;
        #1;
        t = exp_total(a, b, c);
        check("R1 sum", {16'd0, sum}, {16'd0, t[15:0]});
        check("R2 cout", {31'd0, cout}, {31'd0, t[16]});
        check("R5 ovf", {31'd0, ovf}, {31'd0, exp_ovf(a, b, c)});
        if (a[15] != b[15]) check("R6 mixed sign ovf", {31'd0, ovf}, 32'd0);
    endtask

    initial begin
        opa = '0; opb = '0; cin = 1'b0;
        #1;
        check("R1 zero inputs", {16'd0, sum}, 32'd0);
        check("R2 zero inputs", {31'd0, cout}, 32'd0);

        // R3: full propagate chains
        apply(16'hFFFF, 16'h0000, 1'b1);
        check("R3 ffff+0+1 sum", {16'd0, sum}, 32'd0);
        check("R3 ffff+0+1 cout", {31'd0, cout}, 32'd1);
        apply(16'hFFFF, 16'h0001, 1'b0);
        check("R3 ffff+1 cout", {31'd0, cout}, 32'd1);
        apply(16'hAAAA, 16'h5555, 1'b1);
        check("R3 complement chain", {15'd0, cout, sum}, 32'h10000);

        // R4: generate in the lowest slice crossing three propagate slices
        apply(16'hFFF8, 16'h0008, 1'b0);
        check("R4 long slice carry", {15'd0, cout, sum}, 32'h10000);
        apply(16'h00F0, 16'h0010, 1'b0);
        check("R4 stopped carry", {15'd0, cout, sum}, 32'h00100);
        apply(16'h0F00, 16'h0100, 1'b0);
        check("R4 mid slice carry", {15'd0, cout, sum}, 32'h01000);

        // R5 and R6: sign boundaries
        apply(16'h7FFF, 16'h0000, 1'b1);
        check("R5 cin overflow", {31'd0, ovf}, 32'd1);
        apply(16'h8000, 16'h8000, 1'b0);
        check("R5 neg overflow", {31'd0, ovf}, 32'd1);
        apply(16'h8000, 16'hFFFF, 1'b1);
        check("R5 no overflow at min", {31'd0, ovf}, 32'd0);
        apply(16'h7FFF, 16'h8000, 1'b1);
        check("R6 mixed sign carry", {30'd0, cout, ovf}, 32'd2);

        // R7: two input changes inside one low phase, each seen at once
        @(negedge clk);
        opa = 16'h1234; opb = 16'h1111; cin = 1'b0;
        #0.5;
        check("R7 first change", {16'd0, sum}, 32'h2345);
        opa = 16'h4000; opb = 16'h4000; cin = 1'b0;
        #0.5;
        check("R7 second change", {30'd0, ovf, sum[15]}, 32'd3);

        // Random stream, with one vector in four complementary
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = ($urandom_range(3) == 0) ? ~ra : 16'($urandom);
            apply(ra, rb, 1'($urandom));
        end

        done = 1;
    end

    initial begin
        for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule